// File: doc/BRIEF.md
# Compressed-Data Memory Bus Controller

This block drives the control strobes, address and write data for an external byte-wide asynchronous memory that holds a compressed bit-stream. A codec core hands it one access at a time through a valid/ready handshake: a direction flag plus, for writes, a data byte. The controller opens an access cycle with an active-low chip-select. It brings output-enable (reads) or write-enable (writes) low half an input clock later and releases every strobe when the cycle ends. Read bytes are captured on the edge where output-enable rises.

The block runs on a clock at twice the input frequency, so every strobe edge falls on either a full or a half input-clock boundary. An internal phase bit keeps track of which half of the input clock is current. Each access lasts a programmable whole number of input clocks, from one to eight. When the core offers a new request on the last half-cycle of the current access, the next access follows with no gap and chip-select stays low throughout. A counter supplies the memory address. It advances once after each completed access and can be cleared synchronously.

Top module: `cdm_bus_ctrl`

## Requirements
- R1: During and after a synchronous reset, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_addr` is 0, `rd_valid` is 0 and `mem_wdata_oe` is 0.
- R2: An accepted access holds `mem_cs_n` low for exactly 2*(`cfg_len`+1) doubled-clock cycles, where `cfg_len` (0..7 = 1..8 input clocks) is sampled at acceptance; chip-select goes low on the accepting edge.
- R3: N requests accepted back-to-back give one unbroken chip-select low of N*2*(`cfg_len`+1) cycles; requests separated by an idle gap give separate chip-select pulses.
- R4: For a read (`req_wr`=0), `mem_oe_n` goes low one doubled-clock cycle (half an input clock) after chip-select falls and stays low to the end of the access, 2*(`cfg_len`+1)-1 cycles; `mem_we_n` stays 1.
- R5: For a write (`req_wr`=1), `mem_we_n` follows the same timing, `mem_oe_n` stays 1, and `mem_wdata` carries the request byte with `mem_wdata_oe`=1 for the whole access.
- R6: `rd_data` takes the value of `mem_rdata` present on the edge where `mem_oe_n` rises at the end of a read, and `rd_valid` is 1 for exactly that following cycle.
- R7: `mem_addr` is constant during an access and increases by one after each completed access.
- R8: A one-cycle `addr_clr` pulse sets `mem_addr` to 0 on the next edge and takes priority over an increment.
- R9: `req_ready` is 1 only in the second half of an input clock, and only while idle or in the final half-cycle of an access; exactly one access starts per edge where `req_valid` and `req_ready` are both 1.
- R10: Whenever chip-select is high, output-enable and write-enable are high too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the input-clock frequency |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | LEN_W (3) | Access length minus one, in input clocks |
| addr_clr | input | 1 | Clears the address counter |
| req_valid | input | 1 | Core offers an access |
| req_ready | output | 1 | Controller takes the offered access on this edge |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W (8) | Byte to write |
| rd_data | output | DATA_W (8) | Last byte read |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| mem_addr | output | ADDR_W (16) | Memory address |
| mem_wdata | output | DATA_W (8) | Write data to memory |
| mem_wdata_oe | output | 1 | Enable for the write-data drivers |
| mem_rdata | input | DATA_W (8) | Read data from memory |
| mem_cs_n | output | 1 | Chip-select, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_we_n | output | 1 | Write-enable, active low |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 16-bit address and a 3-bit length field. It sweeps all eight access lengths in full, and for every length it runs a write burst, a read burst and two isolated reads against a byte-array memory model. This exercises every distance between a strobe edge and the end of its cycle, including the one-input-clock case, where the enable strobe is low for a single doubled-clock cycle. It also covers both merged and split chip-select patterns. Pulse widths, pulse counts, address values and read data are all predicted by arithmetic on `cfg_len` and the burst size.

// File: rtl/cdm_pkg.sv
package cdm_pkg;
  typedef enum logic {
    ACC_RD = 1'b0,
    ACC_WR = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/cdm_seq.sv
// Access sequencer: input-clock phase, half-cycle counter, request handshake.
module cdm_seq
  import cdm_pkg::*;
#(
  parameter int LEN_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              req_valid,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output acc_kind_e         cur_kind,
  output logic              nxt_active,
  output acc_kind_e         nxt_kind,
  output logic              nxt_mid,
  output logic [DATA_W-1:0] nxt_data
);
  localparam int CNT_W = LEN_W + 1;

  logic              phase_q;
  logic              active_q;
  logic [CNT_W-1:0]  hcnt_q;
  logic [LEN_W-1:0]  len_q;
  acc_kind_e         kind_q;
  logic [DATA_W-1:0] data_q;

  logic              last;
  logic              accept;
  logic [CNT_W-1:0]  hcnt_d;
  logic              active_d;
  logic [LEN_W-1:0]  len_d;
  acc_kind_e         kind_d;
  logic [DATA_W-1:0] data_d;

  // final half-cycle index is 2*(len+1)-1 = {len,1}
  assign last      = active_q && (hcnt_q == {len_q, 1'b1});
  assign req_ready = phase_q && (!active_q || last);
  assign accept    = req_valid && req_ready;
  assign done      = last;
  assign cur_kind  = kind_q;

  always_comb begin
    active_d = active_q;
    hcnt_d   = hcnt_q;
    len_d    = len_q;
    kind_d   = kind_q;
    data_d   = data_q;
    if (accept) begin
      active_d = 1'b1;
      hcnt_d   = '0;
      len_d    = cfg_len;
      kind_d   = req_wr ? ACC_WR : ACC_RD;
      data_d   = req_wdata;
    end else if (last) begin
      active_d = 1'b0;
      hcnt_d   = '0;
    end else if (active_q) begin
      hcnt_d   = hcnt_q + 1'b1;
    end
  end

  assign nxt_active = active_d;
  assign nxt_kind   = kind_d;
  assign nxt_mid    = active_d && (hcnt_d != '0);
  assign nxt_data   = data_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= 1'b0;
      active_q <= 1'b0;
      hcnt_q   <= '0;
      len_q    <= '0;
      kind_q   <= ACC_RD;
      data_q   <= '0;
    end else begin
      phase_q  <= ~phase_q;
      active_q <= active_d;
      hcnt_q   <= hcnt_d;
      len_q    <= len_d;
      kind_q   <= kind_d;
      data_q   <= data_d;
    end
  end
endmodule

// File: rtl/cdm_strobe.sv
// Registered active-low strobes and write-data drive.
module cdm_strobe
  import cdm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nxt_active,
  input  acc_kind_e         nxt_kind,
  input  logic              nxt_mid,
  input  logic [DATA_W-1:0] nxt_data,
  output logic              cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [DATA_W-1:0] wdata,
  output logic              wdata_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n     <= 1'b1;
      oe_n     <= 1'b1;
      we_n     <= 1'b1;
      wdata    <= '0;
      wdata_oe <= 1'b0;
    end else begin
      cs_n     <= !nxt_active;
      oe_n     <= !(nxt_mid && (nxt_kind == ACC_RD));
      we_n     <= !(nxt_mid && (nxt_kind == ACC_WR));
      wdata    <= nxt_data;
      wdata_oe <= nxt_active && (nxt_kind == ACC_WR);
    end
  end
endmodule

// File: rtl/cdm_addr.sv
// Address counter and read-data capture.
module cdm_addr
  import cdm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_clr,
  input  logic              done,
  input  acc_kind_e         cur_kind,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (addr_clr)  addr <= '0;
      else if (done) addr <= addr + 1'b1;
      rd_valid <= done && (cur_kind == ACC_RD);
      if (done && (cur_kind == ACC_RD)) rd_data <= mem_rdata;
    end
  end
endmodule

// File: rtl/cdm_bus_ctrl.sv
module cdm_bus_ctrl
  import cdm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic              clk2x,
  input  logic              rst,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              addr_clr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wdata_oe,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n
);
  logic              done;
  acc_kind_e         cur_kind;
  logic              nxt_active;
  acc_kind_e         nxt_kind;
  logic              nxt_mid;
  logic [DATA_W-1:0] nxt_data;

  cdm_seq #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk2x), .rst(rst), .cfg_len(cfg_len),
    .req_valid(req_valid), .req_wr(req_wr), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .cur_kind(cur_kind),
    .nxt_active(nxt_active), .nxt_kind(nxt_kind),
    .nxt_mid(nxt_mid), .nxt_data(nxt_data)
  );

  cdm_strobe #(.DATA_W(DATA_W)) u_stb (
    .clk(clk2x), .rst(rst),
    .nxt_active(nxt_active), .nxt_kind(nxt_kind),
    .nxt_mid(nxt_mid), .nxt_data(nxt_data),
    .cs_n(mem_cs_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
    .wdata(mem_wdata), .wdata_oe(mem_wdata_oe)
  );

  cdm_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .clk(clk2x), .rst(rst), .addr_clr(addr_clr), .done(done),
    .cur_kind(cur_kind), .mem_rdata(mem_rdata),
    .addr(mem_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/cdm_bus_ctrl_chk.sv
module cdm_bus_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              addr_clr,
  input logic              cs_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] addr
);
  a_r10_oe_within_cs: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> !cs_n);
  a_r10_we_within_cs: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> !cs_n);
  a_r4_single_enable: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n));
  a_r4_oe_late_start: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> oe_n && we_n);
  a_r6_capture_on_oe_rise: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $rose(oe_n));
  a_r7_addr_moves_at_end: assert property (@(posedge clk) disable iff (rst)
    !$stable(addr) |-> ($past(addr_clr) || $rose(oe_n) || $rose(we_n)));
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> cs_n && oe_n && we_n && !rd_valid);
endmodule

bind cdm_bus_ctrl cdm_bus_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk2x), .rst(rst), .addr_clr(addr_clr),
  .cs_n(mem_cs_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
  .rd_valid(rd_valid), .addr(mem_addr)
);

// File: tb/cdm_bus_ctrl_tb_top.sv
module cdm_bus_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk2x = 1'b0;
  logic        rst;
  logic [2:0]  cfg_len;
  logic        addr_clr;
  logic        req_valid;
  logic        req_ready;
  logic        req_wr;
  logic [7:0]  req_wdata;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_wdata_oe;
  logic [7:0]  mem_rdata;
  logic        mem_cs_n, mem_oe_n, mem_we_n;

  always #(CLK_PERIOD/2) clk2x = ~clk2x;

  cdm_bus_ctrl dut_i (
    .clk2x(clk2x), .rst(rst), .cfg_len(cfg_len), .addr_clr(addr_clr),
    .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
    .req_wdata(req_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
    .mem_rdata(mem_rdata), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n)
  );

  // asynchronous byte memory model
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk2x) if (!mem_we_n) mem[mem_addr[7:0]] <= mem_wdata;

  int n_chk = 0, n_fail = 0;
  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor, sampled at the falling edge
  int cs_low, cs_falls, oe_low, oe_falls, we_low, we_falls, acc, rdv, rd_bad;
  int run, run_bad, idle_bad, wdoe_bad, exp_rd, cur_l2;
  logic p_cs, p_oe, p_we;
  bit mon_on = 0;

  task automatic clear_mon(input int l2);
    cs_low = 0; cs_falls = 0; oe_low = 0; oe_falls = 0; we_low = 0; we_falls = 0;
    acc = 0; rdv = 0; rd_bad = 0; run = 0; run_bad = 0; idle_bad = 0; wdoe_bad = 0;
    exp_rd = 0; cur_l2 = l2; p_cs = 1; p_oe = 1; p_we = 1;
  endtask

  always @(negedge clk2x) if (mon_on) begin
    if (req_valid && req_ready) acc++;
    if (!mem_cs_n) begin cs_low++; if (p_cs) cs_falls++; end
    if (!mem_oe_n) begin oe_low++; if (p_oe) oe_falls++; end
    if (!mem_we_n) begin we_low++; if (p_we) we_falls++;
      if (!mem_wdata_oe) wdoe_bad++; end
    if (!mem_oe_n || !mem_we_n) run++;
    else if (run != 0) begin if (run != cur_l2 - 1) run_bad++; run = 0; end
    if (mem_cs_n && (!mem_oe_n || !mem_we_n)) idle_bad++;
    if (rd_valid) begin
      rdv++;
      if (rd_data !== exp_mem[exp_rd]) begin
        rd_bad++;
        $display("FAIL R6 rd_data actual=%0d expected=%0d", rd_data, exp_mem[exp_rd]);
      end
      exp_rd++;
    end
    p_cs = mem_cs_n; p_oe = mem_oe_n; p_we = mem_we_n;
  end

  task automatic burst(input bit wr, input int n, input int l);
    for (int i = 0; i < n; i++) begin
      req_wr = wr;
      req_wdata = 8'((l * 37 + i * 11 + 5) & 255);
      if (wr) exp_mem[i] = req_wdata;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk2x);
      @(negedge clk2x);
    end
    req_valid = 1'b0;
  endtask

  task automatic clr_addr();
    addr_clr = 1'b1; @(negedge clk2x); addr_clr = 1'b0;
    check(mem_addr == 0, "R8 addr clear", int'(mem_addr), 0);
  endtask

  task automatic settle(); repeat (40) @(negedge clk2x); endtask

  bit finished = 0;

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    rst = 1; cfg_len = 0; addr_clr = 0; req_valid = 0; req_wr = 0; req_wdata = 0;
    repeat (4) @(negedge clk2x);
    check(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes in reset", {mem_cs_n, mem_oe_n, mem_we_n}, 7);
    rst = 0;
    @(negedge clk2x);
    check(mem_addr == 0 && !rd_valid && !mem_wdata_oe, "R1 idle after reset", int'(mem_addr), 0);
    mon_on = 1;
    for (int l = 0; l < 8; l++) begin
      int l2;
      l2 = 2 * (l + 1);
      cfg_len = 3'(l);
      // back-to-back writes
      clr_addr(); clear_mon(l2);
      burst(1, 3, l); settle();
      check(acc == 3, "R9 write acceptances", acc, 3);
      check(cs_falls == 1, "R3 merged cs on writes", cs_falls, 1);
      check(cs_low == 3 * l2, "R2 cs low length", cs_low, 3 * l2);
      check(we_low == 3 * (l2 - 1), "R5 we low total", we_low, 3 * (l2 - 1));
      check(we_falls == 3, "R5 we pulses", we_falls, 3);
      check(oe_low == 0, "R5 oe idle on write", oe_low, 0);
      check(wdoe_bad == 0, "R5 write data enable", wdoe_bad, 0);
      check(run_bad == 0, "R5 we pulse width", run_bad, 0);
      check(idle_bad == 0, "R10 strobes inside cs", idle_bad, 0);
      check(mem_addr == 3, "R7 addr after writes", int'(mem_addr), 3);
      for (int i = 0; i < 3; i++)
        check(mem[i] == exp_mem[i], "R5 memory content", mem[i], exp_mem[i]);
      // two isolated reads
      clr_addr(); clear_mon(l2);
      burst(0, 1, l); settle(); burst(0, 1, l); settle();
      check(cs_falls == 2, "R3 split cs", cs_falls, 2);
      check(cs_low == 2 * l2, "R2 cs low length reads", cs_low, 2 * l2);
      check(oe_falls == 2, "R4 oe pulses", oe_falls, 2);
      check(we_low == 0, "R4 we idle on read", we_low, 0);
      check(run_bad == 0, "R4 oe pulse width", run_bad, 0);
      check(rdv == 2 && rd_bad == 0, "R6 read data", rdv, 2);
      check(mem_addr == 2, "R7 addr after reads", int'(mem_addr), 2);
      // back-to-back reads
      clr_addr(); clear_mon(l2);
      burst(0, 3, l); settle();
      check(cs_falls == 1 && cs_low == 3 * l2, "R3 merged cs on reads", cs_low, 3 * l2);
      check(oe_low == 3 * (l2 - 1), "R4 oe low total", oe_low, 3 * (l2 - 1));
      check(rdv == 3 && rd_bad == 0, "R6 burst read data", rdv, 3);
      check(acc == 3, "R9 read acceptances", acc, 3);
      check(idle_bad == 0, "R10 idle strobes", idle_bad, 0);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk2x);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule